// File: doc/BRIEF.md
# Serial DAC Code Register Front End

This block is the digital side of a single-channel serial-input DAC with a 12-bit or 14-bit code. A host writes 16-bit words most significant bit first over a three-wire link: a serial clock, an active-low frame select and a data line. Bits are taken on serial clock falling edges while the frame is open. The word collects in a 16-bit shift register. From there it is copied into the code register that feeds the converter. The copy happens either on a falling edge of an active-low load strobe or, when that strobe is held low, automatically at the close of a frame of exactly 16 bits.

The serial output passes the shift register's top bit, so several devices can be chained. A word pushed in re-emerges 16 falling edges later. While the active-low readback select is low, the serial output instead presents the current code, padded with leading zeros to 16 bits. An active-low clear input forces the code to a parameterised clear value (mid-scale by default). A power-down input is reported on a status output and leaves the stored code alone.

The block runs on a system clock that oversamples every pin through a synchroniser. This clock must be at least eight times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: After reset the code output equals the clear code (0x800 for the default 12-bit width), the serial output is low and the low-power flag is low.
- R2: Each serial clock falling edge seen while the frame select is low shifts the data line into bit 0 of the 16-bit shift register, so the first bit sent ends up as bit 15. Falling edges while the frame select is high change nothing.
- R3: Outside readback the serial output shows bit 15 of the shift register and changes after serial clock falling edges. A bit that was shifted in therefore appears on the serial output 15 falling edges later and has left the register after the 16th.
- R4: When the readback select falls, the serial output presents a 16-bit word MSB first: the code zero-extended, with its two upper bits always zero and bits above the code width also zero. The word advances one bit per serial clock falling edge. When the select is released, the serial output returns to the shift register's bit 15.
- R5: A falling edge on the load strobe copies the low code-width bits of the shift register into the code register, whatever the frame's bit count.
- R6: While the load strobe is held low, the rising edge of the frame select copies the shift register into the code register, but only if that frame saw exactly 16 falling edges.
- R7: A frame with fewer or more than 16 falling edges leaves the code unchanged. After an over-long frame the shift register holds the last 16 bits received.
- R8: While the clear input is low, the code equals the clear code and both load paths are ignored. After release the code keeps the clear value until the next load.
- R9: The low-power flag follows the power-down input. Power-down neither changes the stored code nor blocks loads.
- R10: Each pin passes a two-stage synchroniser, and every output reacts within 4 system clocks of a pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data taken on falling edges |
| frame_n_i | input | 1 | Active-low frame select |
| sdat_i | input | 1 | Serial data in, MSB first |
| load_n_i | input | 1 | Active-low load strobe; held low gives automatic update |
| rdsel_n_i | input | 1 | Active-low readback select |
| clear_n_i | input | 1 | Active-low clear |
| pdown_i | input | 1 | Power-down request |
| sdo_o | output | 1 | Serial output: chain data or readback word |
| code_o | output | DATA_W | Code register contents driven to the converter |
| lowpwr_o | output | 1 | Low-power flag |

## Verification
A shift register slipped by one position shows on the serial output at the very next falling edge, and in the code after the next load. A miscounted frame shows as a code that updates on a short or long frame, or that fails to update on an exact one, within 4 clocks of the frame select rising. A wrong readback load or a broken clear priority is visible on the first readback bit, or in the code 4 clocks after the clear pin or strobe moves. Bench checks sample the serial output after every falling edge, so a fault shows within one bit time.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // serial word length, fixed by the frame format
  localparam int FRAME_W = 16;
  // synchroniser lane assignment
  localparam int LN_SCLK  = 0;
  localparam int LN_FRAME = 1;
  localparam int LN_SDAT  = 2;
  localparam int LN_LOAD  = 3;
  localparam int LN_RDSEL = 4;
  localparam int LN_CLEAR = 5;
  localparam int LN_PDOWN = 6;
  localparam int LANES    = 7;
  // idle levels: active-low lines high, serial clock idles high
  localparam logic [LANES-1:0] LANE_IDLE = 7'b0111011;

  // mid-scale code for a given width
  function automatic int unsigned midscale(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // frame bit counter step, saturating one past a full frame
  function automatic int unsigned count_step(input int unsigned c, input int unsigned full);
    return (c > full) ? c : c + 1;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int N = 7,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= RST_VAL;
    else        prev_o <= pipe[STAGES-1];
  end

  assign lvl_o = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_open,
  input  logic              frame_start,
  input  logic              sclk_fall,
  input  logic              sdat_s,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take   = sclk_fall && frame_open;
  assign full_o = (cnt_q == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      cnt_q  <= '0;
    end else begin
      if (take) word_o <= {word_o[WORD_W-2:0], sdat_s};
      if (frame_start)
        cnt_q <= take ? CNT_W'(1) : '0;
      else if (take)
        cnt_q <= CNT_W'(sdac_pkg::count_step(32'(cnt_q), WORD_W));
    end
  end
endmodule

// File: rtl/sdac_codereg.sv
module sdac_codereg #(
  parameter int DATA_W = 12,
  parameter logic [DATA_W-1:0] CLR_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_act,
  input  logic              load_fall,
  input  logic              auto_fire,
  input  logic [DATA_W-1:0] new_code,
  output logic [DATA_W-1:0] code_o
);
  // priority: clear level, then either load path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      code_o <= CLR_CODE;
    else if (clr_act)                code_o <= CLR_CODE;
    else if (load_fall || auto_fire) code_o <= new_code;
  end
endmodule

// File: rtl/sdac_sdo.sv
module sdac_sdo #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              rd_act,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] code_i,
  input  logic              chain_msb,
  output logic              sdo_o
);
  logic [WORD_W-1:0] rb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rb_q <= '0;
    else if (rd_start)             rb_q <= WORD_W'(code_i);
    else if (rd_act && sclk_fall)  rb_q <= {rb_q[WORD_W-2:0], 1'b0};
  end

  assign sdo_o = rd_act ? rb_q[WORD_W-1] : chain_msb;
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CLR_CODE = DATA_W'(sdac_pkg::midscale(DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdat_i,
  input  logic              load_n_i,
  input  logic              rdsel_n_i,
  input  logic              clear_n_i,
  input  logic              pdown_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] code_o,
  output logic              lowpwr_o
);
  import sdac_pkg::*;
  localparam int WORD_W = FRAME_W;

  logic [LANES-1:0] pins, lvl, prev;
  logic sclk_fall, frame_open, frame_start, frame_end;
  logic sdat_s, load_lvl, load_fall, rd_act, rd_start, clr_act;
  logic full_frame, auto_fire;
  logic [WORD_W-1:0] sh_word;

  assign pins = {pdown_i, clear_n_i, rdsel_n_i, load_n_i, sdat_i, frame_n_i, sclk_i};

  sdac_sync #(.N(LANES), .STAGES(SYNC_STAGES), .RST_VAL(LANE_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins), .lvl_o(lvl), .prev_o(prev)
  );

  // named events, used by the design and by the bound checker
  assign sclk_fall   = prev[LN_SCLK] & ~lvl[LN_SCLK];
  assign frame_open  = ~lvl[LN_FRAME];
  assign frame_start = prev[LN_FRAME] & ~lvl[LN_FRAME];
  assign frame_end   = ~prev[LN_FRAME] & lvl[LN_FRAME];
  assign sdat_s      = prev[LN_SDAT];   // one clock older than the edge: setup margin
  assign load_lvl    = ~lvl[LN_LOAD];
  assign load_fall   = prev[LN_LOAD] & ~lvl[LN_LOAD];
  assign rd_act      = ~lvl[LN_RDSEL];
  assign rd_start    = prev[LN_RDSEL] & ~lvl[LN_RDSEL];
  assign clr_act     = ~lvl[LN_CLEAR] | ~prev[LN_CLEAR];
  assign lowpwr_o    = prev[LN_PDOWN];

  sdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_open(frame_open), .frame_start(frame_start),
    .sclk_fall(sclk_fall), .sdat_s(sdat_s), .word_o(sh_word), .full_o(full_frame)
  );

  assign auto_fire = frame_end & load_lvl & full_frame;

  sdac_codereg #(.DATA_W(DATA_W), .CLR_CODE(CLR_CODE)) u_code (
    .clk(clk), .rst_n(rst_n), .clr_act(clr_act), .load_fall(load_fall),
    .auto_fire(auto_fire), .new_code(sh_word[DATA_W-1:0]), .code_o(code_o)
  );

  sdac_sdo #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_sdo (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_act(rd_act),
    .sclk_fall(sclk_fall), .code_i(code_o), .chain_msb(sh_word[WORD_W-1]), .sdo_o(sdo_o)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int DATA_W = 12,
  parameter logic [DATA_W-1:0] CLR_CODE = '0,
  localparam int WORD_W = sdac_pkg::FRAME_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_fall,
  input logic              frame_open,
  input logic              frame_end,
  input logic              full_frame,
  input logic              auto_fire,
  input logic              load_fall,
  input logic              clr_act,
  input logic              rd_act,
  input logic              rd_start,
  input logic              sdat_s,
  input logic [WORD_W-1:0] sh_word,
  input logic [DATA_W-1:0] code_o,
  input logic              sdo_o
);
  // R8
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> code_o == CLR_CODE);
  // R5
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && !clr_act) |=> code_o == $past(sh_word[DATA_W-1:0]));
  // R6
  auto_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fire && !clr_act) |=> code_o == $past(sh_word[DATA_W-1:0]));
  // R7
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full_frame && !load_fall && !clr_act) |=> $stable(code_o));
  // R9
  code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !load_fall && !frame_end) |=> $stable(code_o));
  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && frame_open) |=> sh_word == {$past(sh_word[WORD_W-2:0]), $past(sdat_s)});
  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall && frame_open) |=> $stable(sh_word));
  // R4
  rb_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (!rd_act || !sdo_o));
endmodule

bind sdac_front sdac_front_chk #(.DATA_W(DATA_W), .CLR_CODE(CLR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .frame_open(frame_open),
  .frame_end(frame_end), .full_frame(full_frame), .auto_fire(auto_fire),
  .load_fall(load_fall), .clr_act(clr_act), .rd_act(rd_act), .rd_start(rd_start),
  .sdat_s(sdat_s), .sh_word(sh_word), .code_o(code_o), .sdo_o(sdo_o)
);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;
  localparam int DW = 12;
  localparam logic [DW-1:0] MID = 12'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, frame_n = 1'b1, sdat = 1'b0, load_n = 1'b1;
  logic rdsel_n = 1'b1, clear_n = 1'b1, pdown = 1'b0;
  logic sdo;
  logic [DW-1:0] code;
  logic lowpwr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0]   exp_sr = '0;
  logic [DW-1:0] exp_code = MID;

  always #2.5 clk = ~clk;

  sdac_front u_sdac_front (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .sdat_i(sdat),
    .load_n_i(load_n), .rdsel_n_i(rdsel_n), .clear_n_i(clear_n), .pdown_i(pdown),
    .sdo_o(sdo), .code_o(code), .lowpwr_o(lowpwr)
  );

  function automatic logic [DW-1:0] low_code(input logic [15:0] w);
    return w[DW-1:0];
  endfunction

  function automatic logic [15:0] rb_image(input logic [DW-1:0] c);
    return {{(16-DW){1'b0}}, c};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_code(input string tag);
    check(code == exp_code, tag, 32'(code), 32'(exp_code));
  endtask

  // drive the load strobe; a falling edge loads unless clear is held
  task automatic set_load(input logic v);
    if (load_n && !v && clear_n) exp_code = low_code(exp_sr);
    load_n = v;
    wait_clk(6);
  endtask

  task automatic pulse_load();
    set_load(1'b0);
    set_load(1'b1);
  endtask

  // send the low n bits of bits, MSB first, checking the chain output after each fall
  task automatic send(input logic [31:0] bits, input int n);
    frame_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      exp_sr = {exp_sr[14:0], bits[i]};
      if (rdsel_n) check(sdo == exp_sr[15], "R3 chain output", 32'(sdo), 32'(exp_sr[15]));
      sclk = 1'b1;
      wait_clk(4);
    end
    frame_n = 1'b1;
    wait_clk(6);
    if (!load_n && n == 16 && clear_n) exp_code = low_code(exp_sr);
  endtask

  task automatic readback(input string tag);
    logic [15:0] img;
    img = rb_image(exp_code);
    rdsel_n = 1'b0;
    wait_clk(6);
    for (int i = 15; i >= 0; i--) begin
      check(sdo == img[i], tag, 32'(sdo), 32'(img[i]));
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
    rdsel_n = 1'b1;
    wait_clk(6);
    check(sdo == exp_sr[15], "R4 release to chain", 32'(sdo), 32'(exp_sr[15]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd7151));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R1
    check_code("R1 reset code");
    check(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 0);
    check(lowpwr == 1'b0, "R1 reset lowpwr", 32'(lowpwr), 0);

    // R5: strobe load, code unchanged before the strobe
    send(32'h0000_A5C3, 16);
    check_code("R5 no load before strobe");
    load_n = 1'b0;
    wait_clk(4);
    check(code == 12'h5C3, "R10 code within 4 clocks", 32'(code), 32'h5C3);
    load_n = 1'b1;
    exp_code = 12'h5C3;
    wait_clk(6);
    check_code("R5 strobe load");

    // R6: strobe held low, exact frame updates
    set_load(1'b0);
    send(32'h0000_3E71, 16);
    check_code("R6 auto update");
    check(code == 12'hE71, "R6 auto value", 32'(code), 32'hE71);

    // R7: short frame with strobe low
    send(32'h0000_0155, 9);
    check_code("R7 short frame ignored");
    // R7: long frame, last 16 bits kept
    send(32'h00AB_CDEF, 24);
    check_code("R7 long frame ignored");
    check(exp_sr == 16'hCDEF, "R7 bench model", 32'(exp_sr), 32'hCDEF);
    set_load(1'b1);
    pulse_load();
    check(code == 12'hDEF, "R7 last 16 bits kept", 32'(code), 32'hDEF);

    // R3: daisy chain, word A then B
    send(32'h0000_1234, 16);
    send(32'h0000_FEDC, 16);

    // R2: falls with frame select high change nothing
    for (int k = 0; k < 5; k++) begin
      sdat = 1'b1;
      sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
    pulse_load();
    check(code == 12'hEDC, "R2 idle falls ignored", 32'(code), 32'hEDC);

    // R4: readback of code
    readback("R4 readback bit");

    // R8: clear
    clear_n = 1'b0;
    exp_code = MID;
    wait_clk(6);
    check_code("R8 clear forces code");
    send(32'h0000_0777, 16);
    pulse_load();
    check_code("R8 strobe ignored under clear");
    set_load(1'b0);
    send(32'h0000_0999, 16);
    check_code("R8 auto ignored under clear");
    clear_n = 1'b1;
    wait_clk(6);
    check_code("R8 clear value kept after release");
    set_load(1'b1);
    pulse_load();
    check(code == 12'h999, "R8 load after release", 32'(code), 32'h999);

    // R9: power down
    pdown = 1'b1;
    wait_clk(6);
    check(lowpwr == 1'b1, "R9 lowpwr set", 32'(lowpwr), 1);
    check_code("R9 code retained");
    send(32'h0000_0BAD, 16);
    pulse_load();
    check(code == 12'hBAD, "R9 load while powered down", 32'(code), 32'hBAD);
    pdown = 1'b0;
    wait_clk(6);
    check(lowpwr == 1'b0, "R9 lowpwr cleared", 32'(lowpwr), 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int mode;
      int n;
      w = 16'($urandom());
      mode = int'($urandom() % 4);
      case (mode)
        0: begin set_load(1'b0); send(32'(w), 16); check_code("R6 random auto"); end
        1: begin set_load(1'b1); send(32'(w), 16); check_code("R5 random pre");
                 pulse_load(); check_code("R5 random strobe"); end
        2: begin set_load(1'b0); n = 1 + int'($urandom() % 15);
                 send(32'(w), n); check_code("R7 random short"); end
        default: begin set_load(1'b0); n = 17 + int'($urandom() % 8);
                 send({16'($urandom()), w}, n); check_code("R7 random long"); end
      endcase
      if (it % 8 == 0) readback("R4 random readback");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule